// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Busy Inhibit

A 2048 x 16 memory with two fully independent synchronous ports, left and right. Each port has an active-low select, an active-low read enable and two active-low write strobes, one for each byte. A port can write both bytes, write one byte, or write one byte and read the other in the same cycle. Read data is registered. A two-bit valid flag comes with the read data, one bit for each byte. A byte that is not valid reads as zero, and this takes the place of a floating bus.

Each port has an effective busy signal, active low, that blocks all of its writes. Reads from that port still proceed. The mode pin selects where busy comes from. In master mode an internal arbiter drives it, and the arbiter's decision is also driven out. In slave mode busy comes from an input pin. A master can therefore share one decision with slave devices that sit beside it to form wider words.

Top module: `bytelane_dpram`

## Requirements
- R1: Data written at an address through either port is returned on either port when that address is read later. Read data and valid flags appear after the clock edge that samples the read request.
- R2: While a port's select is high, that port writes nothing. After the next edge its valid flags are 00 and its read data is 0.
- R3: A byte is written only when select is low, that byte's strobe is low and the port's effective busy is high. The high strobe covers bits 15:8 and the low strobe covers bits 7:0. The other byte keeps its contents.
- R4: A byte's valid flag is set after the edge only if select was low, read enable was low and that byte's strobe was high. Valid bit 1 covers bits 15:8 and bit 0 covers bits 7:0. A byte whose flag is clear reads as 0.
- R5: An effective busy of 0 suppresses every write from the port. Its reads still return data and valid flags.
- R6: With mode = 0 (slave), each port's effective busy is its busy input, and both busy outputs stay at 1.
- R7: With mode = 1 (master), contention means both selects are low and both addresses are equal. While contention lasts, exactly one port, the loser, sees busy 0 in the same cycle, combinationally. Without contention both busy outputs are 1. The busy inputs are ignored in this mode.
- R8: When contention arises, the winner is the port whose select and address were already the same in the previous cycle. If both or neither were unchanged, the left port wins. The winner is kept while contention continues with both ports unchanged.
- R9: A read in the same cycle as a write from the opposite port returns the previous contents. A read one cycle later returns the new data.
- R10: If both ports write the same byte of the same address in one cycle and neither is blocked, the left port's data is stored.
- R11: While reset is low, both valid outputs are 00, both read data outputs are 0, and both busy outputs are 1 when the ports are deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = internal arbiter drives busy, 0 = busy inputs drive it |
| l_cs_n_i | input | 1 | Left select, active low |
| l_oe_n_i | input | 1 | Left read enable, active low |
| l_we_hi_n_i | input | 1 | Left upper-byte write strobe, active low |
| l_we_lo_n_i | input | 1 | Left lower-byte write strobe, active low |
| l_addr_i | input | 11 | Left address |
| l_wdata_i | input | 16 | Left write data |
| l_busy_n_i | input | 1 | Left external busy (slave mode) |
| l_busy_n_o | output | 1 | Left arbiter busy (master mode), else 1 |
| l_rdata_o | output | 16 | Left read data |
| l_rvalid_o | output | 2 | Left per-byte valid {upper, lower} |
| r_cs_n_i | input | 1 | Right select, active low |
| r_oe_n_i | input | 1 | Right read enable, active low |
| r_we_hi_n_i | input | 1 | Right upper-byte write strobe, active low |
| r_we_lo_n_i | input | 1 | Right lower-byte write strobe, active low |
| r_addr_i | input | 11 | Right address |
| r_wdata_i | input | 16 | Right write data |
| r_busy_n_i | input | 1 | Right external busy (slave mode) |
| r_busy_n_o | output | 1 | Right arbiter busy (master mode), else 1 |
| r_rdata_o | output | 16 | Right read data |
| r_rvalid_o | output | 2 | Right per-byte valid {upper, lower} |

## Verification
Busy is combinational, so it is due in the same cycle as the request. The bench compares it at mid-cycle, after the inputs have settled and before the edge that acts on it. Read data and valid flags are due one edge after the request. They are compared 1 ns after that edge against a model that was updated at the same edge. Memory is updated at that edge too, so a read of a freshly written byte is expected one request later. The model tracks which bytes have been written and compares data only for those.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int LANE_W = 8;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_sel_i,
  input  logic          r_sel_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic [AW-1:0] r_addr_i,
  output logic          l_busy_n_o,
  output logic          r_busy_n_o
);
  logic          l_sel_q, r_sel_q, contend_q, win_l_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          contend, l_steady, r_steady, win_l;

  assign contend  = l_sel_i && r_sel_i && (l_addr_i == r_addr_i);
  assign l_steady = l_sel_q && (l_addr_q == l_addr_i);
  assign r_steady = r_sel_q && (r_addr_q == r_addr_i);

  always_comb begin
    if (contend_q && l_steady && r_steady) win_l = win_l_q;
    else                                   win_l = !(r_steady && !l_steady);
  end

  assign l_busy_n_o = !(contend && !win_l);
  assign r_busy_n_o = !(contend && win_l);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_sel_q   <= 1'b0;
      r_sel_q   <= 1'b0;
      l_addr_q  <= '0;
      r_addr_q  <= '0;
      contend_q <= 1'b0;
      win_l_q   <= 1'b1;
    end else begin
      l_sel_q   <= l_sel_i;
      r_sel_q   <= r_sel_i;
      l_addr_q  <= l_addr_i;
      r_addr_q  <= r_addr_i;
      contend_q <= contend;
      win_l_q   <= win_l;
    end
  end

  assert_one_loser_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_n_o && !r_busy_n_o));

  assert_hold_winner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (contend && $past(contend) && l_steady && r_steady) |-> $stable(l_busy_n_o));
endmodule

// File: rtl/dpram_port.sv
module dpram_port #(
  parameter int LANES = 2,
  parameter int LW    = 8,
  localparam int DW   = LANES * LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             oe_n_i,
  input  logic [LANES-1:0] we_n_i,
  input  logic             busy_n_i,
  input  logic [DW-1:0]    raw_q_i,
  output logic [LANES-1:0] wr_lane_o,
  output logic [DW-1:0]    rdata_o,
  output logic [LANES-1:0] rvalid_o
);
  logic [LANES-1:0] rd_lane;

  assign wr_lane_o = ~we_n_i & {LANES{!cs_n_i && busy_n_i}};
  // a strobed lane is an input that cycle, never an output
  assign rd_lane   = we_n_i & {LANES{!cs_n_i && !oe_n_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= '0;
    else         rvalid_o <= rd_lane;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign rdata_o[g*LW +: LW] = rvalid_o[g] ? raw_q_i[g*LW +: LW] : '0;
  end

  assert_deselect_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (rvalid_o == '0));

  assert_strobe_not_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rvalid_o & ~$past(we_n_i)) == '0));
endmodule

// File: rtl/dpram_core.sv
module dpram_core #(
  parameter int AW    = 11,
  parameter int LANES = 2,
  parameter int LW    = 8,
  localparam int DW    = LANES * LW,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk_i,
  input  logic [AW-1:0]    l_addr_i,
  input  logic [AW-1:0]    r_addr_i,
  input  logic [LANES-1:0] l_wr_i,
  input  logic [LANES-1:0] r_wr_i,
  input  logic [DW-1:0]    l_wdata_i,
  input  logic [DW-1:0]    r_wdata_i,
  output logic [DW-1:0]    l_q_o,
  output logic [DW-1:0]    r_q_o
);
  logic same_addr;
  assign same_addr = (l_addr_i == r_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic          r_ok;
    // left keeps a same-lane same-address collision
    assign r_ok = r_wr_i[g] && !(l_wr_i[g] && same_addr);

    always_ff @(posedge clk_i) begin
      if (l_wr_i[g]) mem[l_addr_i] <= l_wdata_i[g*LW +: LW];
      if (r_ok)      mem[r_addr_i] <= r_wdata_i[g*LW +: LW];
      l_q_o[g*LW +: LW] <= mem[l_addr_i];
      r_q_o[g*LW +: LW] <= mem[r_addr_i];
    end
  end
endmodule

// File: rtl/bytelane_dpram.sv
module bytelane_dpram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  localparam int LW    = dpram_pkg::LANE_W,
  localparam int LANES = DATA_W / LW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_cs_n_i,
  input  logic              l_oe_n_i,
  input  logic              l_we_hi_n_i,
  input  logic              l_we_lo_n_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_n_i,
  output logic              l_busy_n_o,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [LANES-1:0]  l_rvalid_o,
  input  logic              r_cs_n_i,
  input  logic              r_oe_n_i,
  input  logic              r_we_hi_n_i,
  input  logic              r_we_lo_n_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_n_i,
  output logic              r_busy_n_o,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic [LANES-1:0]  r_rvalid_o
);
  logic             l_arb_n, r_arb_n, l_eff_n, r_eff_n;
  logic [LANES-1:0] l_wr, r_wr;
  logic [DATA_W-1:0] l_q, r_q;

  dpram_arbiter #(.AW(ADDR_W)) u_arb (
    .clk_i, .rst_ni,
    .l_sel_i(!l_cs_n_i), .r_sel_i(!r_cs_n_i),
    .l_addr_i, .r_addr_i,
    .l_busy_n_o(l_arb_n), .r_busy_n_o(r_arb_n)
  );

  assign l_eff_n    = master_i ? l_arb_n : l_busy_n_i;
  assign r_eff_n    = master_i ? r_arb_n : r_busy_n_i;
  assign l_busy_n_o = master_i ? l_arb_n : 1'b1;
  assign r_busy_n_o = master_i ? r_arb_n : 1'b1;

  dpram_port #(.LANES(LANES), .LW(LW)) u_lport (
    .clk_i, .rst_ni, .cs_n_i(l_cs_n_i), .oe_n_i(l_oe_n_i),
    .we_n_i({l_we_hi_n_i, l_we_lo_n_i}), .busy_n_i(l_eff_n), .raw_q_i(l_q),
    .wr_lane_o(l_wr), .rdata_o(l_rdata_o), .rvalid_o(l_rvalid_o)
  );

  dpram_port #(.LANES(LANES), .LW(LW)) u_rport (
    .clk_i, .rst_ni, .cs_n_i(r_cs_n_i), .oe_n_i(r_oe_n_i),
    .we_n_i({r_we_hi_n_i, r_we_lo_n_i}), .busy_n_i(r_eff_n), .raw_q_i(r_q),
    .wr_lane_o(r_wr), .rdata_o(r_rdata_o), .rvalid_o(r_rvalid_o)
  );

  dpram_core #(.AW(ADDR_W), .LANES(LANES), .LW(LW)) u_core (
    .clk_i, .l_addr_i, .r_addr_i, .l_wr_i(l_wr), .r_wr_i(r_wr),
    .l_wdata_i, .r_wdata_i, .l_q_o(l_q), .r_q_o(r_q)
  );

  assert_slave_busy_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_n_o && r_busy_n_o));
endmodule

// File: tb/bytelane_dpram_bench.sv
module bytelane_dpram_bench;
  logic clk = 0, rst_n = 0, master = 1;
  logic l_cs_n = 1, l_oe_n = 1, l_busy_ni = 1, r_cs_n = 1, r_oe_n = 1, r_busy_ni = 1;
  logic [1:0] l_we_n = 2'b11, r_we_n = 2'b11;
  logic [10:0] l_addr = 0, r_addr = 0;
  logic [15:0] l_wd = 0, r_wd = 0;
  logic l_busy_no, r_busy_no;
  logic [15:0] l_rd, r_rd;
  logic [1:0] l_rv, r_rv;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [15:0] m_mem [2048];
  bit [1:0] m_known [2048];
  bit m_lsel_q = 0, m_rsel_q = 0, m_cont_q = 0, m_winl_q = 1;
  logic [10:0] m_la_q = 0, m_ra_q = 0;

  always #10 clk = ~clk;

  bytelane_dpram u_bytelane_dpram (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_cs_n_i(l_cs_n), .l_oe_n_i(l_oe_n), .l_we_hi_n_i(l_we_n[1]), .l_we_lo_n_i(l_we_n[0]),
    .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_busy_n_i(l_busy_ni), .l_busy_n_o(l_busy_no),
    .l_rdata_o(l_rd), .l_rvalid_o(l_rv),
    .r_cs_n_i(r_cs_n), .r_oe_n_i(r_oe_n), .r_we_hi_n_i(r_we_n[1]), .r_we_lo_n_i(r_we_n[0]),
    .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_busy_n_i(r_busy_ni), .r_busy_n_o(r_busy_no),
    .r_rdata_o(r_rd), .r_rvalid_o(r_rv)
  );

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_data(logic [1:0] v, logic [15:0] d, bit [1:0] k,
                                           logic [15:0] act);
    logic [15:0] e;
    for (int g = 0; g < 2; g++) begin
      if (!v[g])      e[g*8 +: 8] = 8'h00;
      else if (k[g])  e[g*8 +: 8] = d[g*8 +: 8];
      else            e[g*8 +: 8] = act[g*8 +: 8]; // never written: content undefined
    end
    return e;
  endfunction

  task automatic idle();
    l_cs_n = 1; l_oe_n = 1; l_we_n = 2'b11; r_cs_n = 1; r_oe_n = 1; r_we_n = 2'b11;
  endtask

  task automatic lset(bit cs, bit oe, logic [1:0] we, logic [10:0] a, logic [15:0] d);
    l_cs_n = cs; l_oe_n = oe; l_we_n = we; l_addr = a; l_wd = d;
  endtask

  task automatic rset(bit cs, bit oe, logic [1:0] we, logic [10:0] a, logic [15:0] d);
    r_cs_n = cs; r_oe_n = oe; r_we_n = we; r_addr = a; r_wd = d;
  endtask

  task automatic step(string tag);
    bit lsel, rsel, cont, lst, rst_, winl, lb, rb, le, re;
    logic [1:0] lw, rw, lv, rv;
    logic [15:0] ld, rd_;
    bit [1:0] lk, rk;
    @(negedge clk);
    #2;
    lsel = !l_cs_n; rsel = !r_cs_n;
    cont = lsel && rsel && (l_addr == r_addr);
    lst  = m_lsel_q && (m_la_q == l_addr);
    rst_ = m_rsel_q && (m_ra_q == r_addr);
    if (m_cont_q && lst && rst_) winl = m_winl_q;
    else winl = !(rst_ && !lst);
    lb = !(cont && !winl); rb = !(cont && winl);
    check(tag, "l_busy_n_o", {15'd0, l_busy_no}, {15'd0, master ? lb : 1'b1});
    check(tag, "r_busy_n_o", {15'd0, r_busy_no}, {15'd0, master ? rb : 1'b1});
    le = master ? lb : l_busy_ni;
    re = master ? rb : r_busy_ni;
    @(posedge clk);
    lw = ~l_we_n & {2{lsel && le}};
    rw = ~r_we_n & {2{rsel && re}};
    lv = l_we_n & {2{lsel && !l_oe_n}};
    rv = r_we_n & {2{rsel && !r_oe_n}};
    ld = m_mem[l_addr]; lk = m_known[l_addr];
    rd_ = m_mem[r_addr]; rk = m_known[r_addr];
    for (int g = 0; g < 2; g++) begin
      if (rw[g]) begin m_mem[r_addr][g*8 +: 8] = r_wd[g*8 +: 8]; m_known[r_addr][g] = 1; end
      if (lw[g]) begin m_mem[l_addr][g*8 +: 8] = l_wd[g*8 +: 8]; m_known[l_addr][g] = 1; end
    end
    m_lsel_q = lsel; m_rsel_q = rsel; m_la_q = l_addr; m_ra_q = r_addr;
    m_cont_q = cont; m_winl_q = winl;
    #1;
    check(tag, "l_rvalid_o", {14'd0, l_rv}, {14'd0, lv});
    check(tag, "r_rvalid_o", {14'd0, r_rv}, {14'd0, rv});
    check(tag, "l_rdata_o", l_rd, exp_data(lv, ld, lk, l_rd));
    check(tag, "r_rdata_o", r_rd, exp_data(rv, rd_, rk, r_rd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) m_known[i] = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    check("R11", "l_rvalid_o", {14'd0, l_rv}, 16'd0);
    check("R11", "r_rvalid_o", {14'd0, r_rv}, 16'd0);
    check("R11", "l_rdata_o", l_rd, 16'd0);
    check("R11", "busy_n_o", {14'd0, l_busy_no, r_busy_no}, 16'd3);
    rst_n = 1;
    step("R11");

    // R1: full-word writes from left, read back on both ports
    for (int i = 0; i < 4; i++) begin
      lset(0, 1, 2'b00, 11'(i * 500 + 3), 16'hA000 + 16'(i)); step("R1");
    end
    lset(0, 1, 2'b00, 11'd2047, 16'h7E57); step("R1");
    idle();
    for (int i = 0; i < 4; i++) begin
      lset(0, 0, 2'b11, 11'(i * 500 + 3), 0); rset(0, 0, 2'b11, 11'd2047, 0); step("R1");
    end
    idle(); step("R1");

    // R3 / R4: single-byte writes, write one byte while reading the other
    lset(0, 1, 2'b10, 11'd3, 16'h1122); step("R3");
    lset(0, 1, 2'b01, 11'd503, 16'h3344); step("R3");
    lset(0, 0, 2'b10, 11'd3, 16'h5566); step("R4");
    lset(0, 0, 2'b01, 11'd503, 16'h7788); step("R4");
    lset(0, 1, 2'b11, 11'd3, 0); step("R4");        // oe high: nothing valid
    lset(0, 0, 2'b11, 11'd3, 0); step("R3");
    lset(0, 0, 2'b11, 11'd503, 0); step("R3");

    // R2: deselected port with strobes low writes nothing
    idle(); lset(1, 0, 2'b00, 11'd3, 16'hDEAD); step("R2");
    lset(0, 0, 2'b11, 11'd3, 0); step("R2");
    idle(); step("R2");

    // R5 / R6: slave mode, external busy blocks writes, reads continue
    master = 0;
    l_busy_ni = 0; lset(0, 1, 2'b00, 11'd3, 16'hBAD0); step("R5");
    lset(0, 0, 2'b11, 11'd3, 0); step("R5");
    l_busy_ni = 1; step("R6");
    r_busy_ni = 0; rset(0, 0, 2'b10, 11'd1003, 16'hBAD1); step("R5");
    r_busy_ni = 1; rset(0, 0, 2'b11, 11'd1003, 0); step("R5");

    // R9: write-through timing between ports
    idle(); rset(0, 1, 2'b00, 11'd1503, 16'hC0DE); lset(0, 0, 2'b11, 11'd1503, 0); step("R9");
    rset(1, 1, 2'b11, 0, 0); step("R9");

    // R10: colliding writes in slave mode, left kept
    lset(0, 1, 2'b00, 11'd9, 16'h1111); rset(0, 1, 2'b01, 11'd9, 16'h2222); step("R10");
    idle(); lset(0, 0, 2'b11, 11'd9, 0); step("R10");

    // R7 / R8: master arbitration orderings
    master = 1; l_busy_ni = 0; r_busy_ni = 0; idle(); step("R7");
    lset(0, 0, 2'b11, 11'd40, 0); step("R8");                 // left arrives first
    rset(0, 1, 2'b00, 11'd40, 16'hFFFF); step("R8");          // right loses, write blocked
    step("R8"); step("R8");
    idle(); step("R7");
    rset(0, 0, 2'b11, 11'd40, 0); step("R8");                 // right arrives first
    lset(0, 1, 2'b00, 11'd40, 16'hEEEE); step("R8");
    step("R8");
    idle(); step("R7");
    lset(0, 1, 2'b00, 11'd41, 16'h4141); rset(0, 1, 2'b00, 11'd41, 16'h4242); step("R8"); // tie
    lset(0, 0, 2'b11, 11'd40, 0); rset(0, 0, 2'b11, 11'd41, 0); step("R7");
    idle(); step("R7");

    // mixed traffic on a narrow address window, both modes
    for (int ph = 0; ph < 2; ph++) begin
      master = (ph == 0);
      for (int i = 0; i < 1500; i++) begin
        lset(($urandom % 4) == 0, $urandom % 2, 2'($urandom), 11'($urandom % 6), 16'($urandom));
        rset(($urandom % 4) == 0, $urandom % 2, 2'($urandom), 11'($urandom % 6), 16'($urandom));
        l_busy_ni = ($urandom % 5) != 0; r_busy_ni = ($urandom % 5) != 0;
        step(ph == 0 ? "R7" : "R5");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule